// File: doc/BRIEF.md
# ATA DMA Command Decoder

This block sits behind a disk channel's command register and reacts each time a new opcode byte is written there. For the DMA read and DMA write opcodes it checks the starting block address against the drive's capacity and loads the transfer parameters: a byte length and a start LBA. When the channel's DMA engine has been armed, it also issues a one-cycle start pulse with the transfer direction and holds the drive busy until the engine reports completion. A sector count of zero requests 256 sectors.

A group of standby, idle and sleep opcodes needs no data movement. These opcodes finish in the cycle after they are written, with a fixed status value and an interrupt. Any other opcode, and any DMA opcode with an address that cannot be served, is refused: the block reports an error and sets the abort flag in the error register. Every output is registered, so each reaction shows up one clock after the write that caused it.

Top module: `ata_cmd_decoder`

## Requirements
- R1: After reset the status byte is 0x40 (ready only), the error byte is 0x00, and `irq` and `dma_start` are low.
- R2: Opcodes 0xC8 and 0xC9 are DMA reads (`dma_dir`=0) and opcode 0xCA is a DMA write (`dma_dir`=1). When the address is valid, `xfer_lba` takes the `lba_in` value and `xfer_len` takes the sector count times SECTOR_BYTES, one cycle after `cmd_wr`.
- R3: A valid DMA command accepted while `dma_active` is high pulses `dma_start` for exactly one cycle, one cycle after `cmd_wr`. In that same cycle the status byte becomes 0x80 (bit 7 = busy).
- R4: For a DMA command, a `sect_cnt` of 0 is treated as 256 sectors.
- R5: A DMA command is aborted when `lba_mode` is low or when `lba_in` plus the sector count exceeds CAPACITY. An abort sets the status to 0x41 (ready, bit 0 = error), sets the error byte to 0x04 (bit 2 = abort), pulses `irq` and gives no start. Any command that is not aborted clears the error byte to 0x00.
- R6: A valid DMA command accepted while `dma_active` is low still loads the transfer parameters, but gives no start pulse and no interrupt, and leaves the status byte unchanged.
- R7: Opcodes 0xE0, 0xE1, 0xE2, 0xE3, 0xE6, 0x94, 0x95, 0x96, 0x97 and 0x99 set the status to 0x40, clear the error byte and pulse `irq` one cycle after `cmd_wr`.
- R8: Busy holds until `dma_done` arrives. The cycle after `dma_done`, the status becomes 0x50 (ready, bit 4 = seek complete) and `irq` pulses for one cycle.
- R9: An opcode outside the DMA and power groups is aborted as in R5.
- R10: While busy, a command write is ignored: no outputs change and there is no interrupt. When not busy, `dma_done` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | One-cycle strobe: `cmd_byte` is written |
| cmd_byte | input | 8 | Command opcode |
| sect_cnt | input | 8 | Sector count register (0 means 256) |
| lba_in | input | LBA_W | Start address assembled from the address registers |
| lba_mode | input | 1 | Address registers hold a linear block address |
| dma_active | input | 1 | Channel DMA engine is armed |
| dma_done | input | 1 | One-cycle pulse: the engine has finished the transfer |
| dma_start | output | 1 | One-cycle pulse that starts the engine |
| dma_dir | output | 1 | 0 = read from drive, 1 = write to drive |
| xfer_len | output | LEN_W | Transfer length in bytes |
| xfer_lba | output | LBA_W | First block of the transfer |
| status | output | 8 | Drive status byte |
| err_reg | output | 8 | Drive error byte |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bench builds the block with LBA_W=16, SECTOR_BYTES=512 and CAPACITY=1000. The small capacity puts the end of the medium within reach of the tests: a single sector at block 999 is the last legal transfer, and a two-sector request at that block has to abort. It also lets a 256-sector request starting at block 0 fit. With the default sector size the zero-count case yields a 131072-byte length, which exercises the top bit of `xfer_len`.

// File: rtl/ata_cmd_decoder.sv
module ata_cmd_decoder #(
  parameter int LBA_W        = 28,
  parameter int SECTOR_BYTES = 512,
  parameter int CAPACITY     = 1 << 24,
  localparam int LEN_W       = 9 + $clog2(SECTOR_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_byte,
  input  logic [7:0]       sect_cnt,
  input  logic [LBA_W-1:0] lba_in,
  input  logic             lba_mode,
  input  logic             dma_active,
  input  logic             dma_done,
  output logic             dma_start,
  output logic             dma_dir,
  output logic [LEN_W-1:0] xfer_len,
  output logic [LBA_W-1:0] xfer_lba,
  output logic [7:0]       status,
  output logic [7:0]       err_reg,
  output logic             irq
);
  localparam int OFS_W = $clog2(SECTOR_BYTES);
  localparam logic [LBA_W:0] CAP = (LBA_W+1)'(CAPACITY);

  logic busy, accept, is_dma, is_pwr, addr_ok;
  logic [8:0] cnt9;
  logic [LBA_W:0] end_blk;

  assign busy    = status[7];
  assign accept  = cmd_wr && !busy;
  assign cnt9    = (sect_cnt == 8'd0) ? 9'd256 : {1'b0, sect_cnt};
  assign end_blk = {1'b0, lba_in} + (LBA_W+1)'(cnt9);
  assign addr_ok = lba_mode && (end_blk <= CAP);
  assign is_dma  = cmd_byte inside {8'hC8, 8'hC9, 8'hCA};
  assign is_pwr  = cmd_byte inside {8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6,
                                    8'h94, 8'h95, 8'h96, 8'h97, 8'h99};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status    <= 8'h40;
      err_reg   <= 8'h00;
      irq       <= 1'b0;
      dma_start <= 1'b0;
      dma_dir   <= 1'b0;
      xfer_len  <= '0;
      xfer_lba  <= '0;
    end else begin
      irq       <= 1'b0;
      dma_start <= 1'b0;
      if (accept) begin
        if (is_dma && addr_ok) begin
          xfer_len <= {cnt9, {OFS_W{1'b0}}};
          xfer_lba <= lba_in;
          dma_dir  <= (cmd_byte == 8'hCA);
          err_reg  <= 8'h00;
          if (dma_active) begin
            dma_start <= 1'b1;
            status    <= 8'h80;
          end
        end else if (is_pwr) begin
          status  <= 8'h40;
          err_reg <= 8'h00;
          irq     <= 1'b1;
        end else begin
          status  <= 8'h41;
          err_reg <= 8'h04;
          irq     <= 1'b1;
        end
      end else if (busy && dma_done) begin
        status <= 8'h50;
        irq    <= 1'b1;
      end
    end
  end

  // R3
  start_needs_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> $past(cmd_wr && dma_active));

  // R3
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> (status[7] && xfer_len != '0));

  // R8
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !dma_done) |=> status[7]);

  // R8
  irq_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !status[7]);

  // R5
  abort_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_reg[2] |-> status[0]);

  // R10
  busy_ignores_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status[7]) && !$past(dma_done)) |-> ($stable(xfer_lba) && $stable(err_reg)));
endmodule

// File: tb/tb_ata_cmd_decoder.sv
module tb_ata_cmd_decoder;
  localparam int LBA_W = 16;
  localparam int LEN_W = 18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0, lba_mode = 1'b1, dma_active = 1'b0, dma_done = 1'b0;
  logic [7:0] cmd_byte = 8'h00, sect_cnt = 8'h00;
  logic [LBA_W-1:0] lba_in = '0;
  logic dma_start, dma_dir, irq;
  logic [LEN_W-1:0] xfer_len;
  logic [LBA_W-1:0] xfer_lba;
  logic [7:0] status, err_reg;

  int n_chk = 0, n_bad = 0, cyc = 0;

  ata_cmd_decoder #(.LBA_W(LBA_W), .SECTOR_BYTES(512), .CAPACITY(1000)) dut (
    .clk, .rst_n, .cmd_wr, .cmd_byte, .sect_cnt, .lba_in, .lba_mode,
    .dma_active, .dma_done, .dma_start, .dma_dir, .xfer_len, .xfer_lba,
    .status, .err_reg, .irq);

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected < 20000", cyc);
        summary();
      end
    end
  end

  task automatic issue(logic [7:0] op, logic [7:0] cnt, logic [LBA_W-1:0] lba,
                       logic mode, logic act);
    @(negedge clk);
    cmd_byte = op; sect_cnt = cnt; lba_in = lba; lba_mode = mode;
    dma_active = act; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic finish_dma();
    @(negedge clk);
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    check("R8 status after done", status, 8'h50);
    check("R8 irq after done", irq, 1);
    @(negedge clk);
    check("R8 irq one cycle", irq, 0);
  endtask

  task automatic t_reset();
    check("R1 status", status, 8'h40);
    check("R1 err", err_reg, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 start", dma_start, 0);
  endtask

  task automatic t_read();
    issue(8'hC8, 8'd8, 16'd100, 1'b1, 1'b1);
    check("R3 start", dma_start, 1);
    check("R2 dir read", dma_dir, 0);
    check("R2 len", xfer_len, 32'd4096);
    check("R2 lba", xfer_lba, 32'd100);
    check("R3 busy", status, 8'h80);
    check("R3 no irq", irq, 0);
    @(negedge clk);
    check("R3 start one cycle", dma_start, 0);
    repeat (3) @(negedge clk);
    check("R8 busy holds", status, 8'h80);
    finish_dma();
  endtask

  task automatic t_zero_count();
    issue(8'hC9, 8'd0, 16'd0, 1'b1, 1'b1);
    check("R4 len 256 sectors", xfer_len, 32'd131072);
    check("R4 start", dma_start, 1);
    finish_dma();
  endtask

  task automatic t_write_last();
    issue(8'hCA, 8'd1, 16'd999, 1'b1, 1'b1);
    check("R2 dir write", dma_dir, 1);
    check("R2 len write", xfer_len, 32'd512);
    check("R2 lba last", xfer_lba, 32'd999);
    check("R3 start write", dma_start, 1);
    finish_dma();
  endtask

  task automatic t_abort_range();
    issue(8'hC8, 8'd2, 16'd999, 1'b1, 1'b1);
    check("R5 status", status, 8'h41);
    check("R5 err", err_reg, 8'h04);
    check("R5 irq", irq, 1);
    check("R5 no start", dma_start, 0);
    check("R5 lba kept", xfer_lba, 32'd999);
    issue(8'hC9, 8'd1, 16'd5, 1'b0, 1'b1);
    check("R5 chs abort status", status, 8'h41);
    check("R5 chs abort start", dma_start, 0);
    check("R5 chs abort irq", irq, 1);
  endtask

  task automatic t_inactive();
    issue(8'hC8, 8'd4, 16'd10, 1'b1, 1'b0);
    check("R6 no start", dma_start, 0);
    check("R6 no irq", irq, 0);
    check("R6 len", xfer_len, 32'd2048);
    check("R6 lba", xfer_lba, 32'd10);
    check("R6 status unchanged", status, 8'h41);
    check("R5 err cleared", err_reg, 8'h00);
  endtask

  task automatic t_power();
    logic [7:0] ops [10] = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6,
                             8'h94, 8'h95, 8'h96, 8'h97, 8'h99};
    for (int i = 0; i < 10; i++) begin
      issue(8'h20, 8'd1, 16'd0, 1'b1, 1'b0);
      check("R9 unknown abort", err_reg, 8'h04);
      check("R9 unknown status", status, 8'h41);
      issue(ops[i], 8'd1, 16'd0, 1'b1, 1'b1);
      check("R7 status", status, 8'h40);
      check("R7 err", err_reg, 8'h00);
      check("R7 irq", irq, 1);
      check("R7 no start", dma_start, 0);
    end
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
    check("R10 idle done status", status, 8'h40);
    check("R10 idle done irq", irq, 0);
    issue(8'hC8, 8'd3, 16'd50, 1'b1, 1'b1);
    check("R3 busy again", status, 8'h80);
    issue(8'hE0, 8'd1, 16'd0, 1'b1, 1'b1);
    check("R10 busy status", status, 8'h80);
    check("R10 busy irq", irq, 0);
    issue(8'hCA, 8'd9, 16'd7, 1'b1, 1'b1);
    check("R10 busy lba", xfer_lba, 32'd50);
    check("R10 busy dir", dma_dir, 0);
    check("R10 busy start", dma_start, 0);
    finish_dma();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_zero_count();
    t_write_last();
    t_abort_range();
    t_inactive();
    t_power();
    t_busy_ignore();
    summary();
  end
endmodule